// File: doc/BRIEF.md
# Memory Reference-Voltage Training Sequencer

This block steps a multi-lane memory data interface through reference-voltage training. For every byte lane and every rank it runs a fixed sequence of probes. It first checks the programmed starting references. It then sweeps the write-side reference, which is held inside the memory device, and checks the value it chose. Last, it sweeps the read-side reference, which is held in the host I/O, and checks that value too. An external tester carries out each probe. The sequencer presents the lane, the rank, the phase and the two reference codes, and it holds them until the tester answers with a valid strobe and a pass/fail bit.

For each sweep, the sequencer finds the widest contiguous run of passing codes and keeps the midpoint of that run as the operating code. If no code passes, the lane/rank error bit is set and the starting value stays in place. A failed check sets one bit of the lane's three-bit failing-phase code. After the last probe of the last lane the block raises a done flag. A global error output is high whenever any error or phase bit is set. A start pulse clears every result and begins again. A start pulse that arrives while the sequence runs is ignored.

Top module: `vrt_train_seq`

## Requirements
- R1: A start pulse while idle sets busy on the next edge, clears done, every error bit and every phase bit, and loads every lane/rank optimum with the starting codes. A start pulse while busy changes nothing.
- R2: Lanes are visited in ascending order, and ranks in ascending order within a lane. For each lane/rank the phases run in this order on req_phase_o: 0 initial check, 1 write sweep, 2 write check, 3 read sweep, 4 read check.
- R3: A sweep probes codes 0 to NUM_CODES-1 in ascending order. Every request field holds until a cycle with req_o and rsp_valid_i both high, and advances on the edge that ends that cycle.
- R4: The codes presented with each probe depend on the phase. In phase 0 both codes are the current optima, which equal the starting codes. In phase 1 the write code is the sweep code and the read code is the current read optimum. In phase 2 both codes are the current optima. In phase 3 the write code is the write optimum and the read code is the sweep code. In phase 4 both codes are the optima.
- R5: The chosen optimum is start+(len-1)/2, using integer division, of the widest contiguous run of passing codes. When two runs are equally wide, the run with the lower start is used. The result is visible one cycle after the last sweep handshake.
- R6: If no code passes in a sweep, the error bit at index lane*NUM_RANKS+rank of mem_err_o (write sweep) or host_err_o (read sweep) is set, and the optimum keeps its starting code.
- R7: A failed check sets a bit of phase_err_o at index lane*3+k. k=0 is the initial check (either rank), k=1 is the write check and k=2 is the read check.
- R8: err_o is the OR of all bits of mem_err_o, host_err_o and phase_err_o.
- R9: done_o rises on the edge that ends the read-check handshake of the last rank of the last lane. At the same edge busy_o and req_o fall.
- R10: After reset, busy_o, done_o, err_o, req_o, all error and phase bits, and all optima are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| init_mem_code_i | input | CODE_W | Starting write-side reference code |
| init_host_code_i | input | CODE_W | Starting read-side reference code |
| req_o | output | 1 | Probe request, held until answered |
| req_lane_o | output | LANE_W | Lane under test |
| req_rank_o | output | RANK_W | Rank under test |
| req_phase_o | output | 3 | Phase of the probe (0..4) |
| req_mem_code_o | output | CODE_W | Write-side code to apply for the probe |
| req_host_code_o | output | CODE_W | Read-side code to apply for the probe |
| rsp_valid_i | input | 1 | Tester answer strobe |
| rsp_pass_i | input | 1 | Tester result, 1 = pass |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Sequence finished |
| err_o | output | 1 | Any error or phase bit set |
| mem_err_o | output | NUM_LANES*NUM_RANKS | Write sweep found no pass, per lane/rank |
| host_err_o | output | NUM_LANES*NUM_RANKS | Read sweep found no pass, per lane/rank |
| phase_err_o | output | NUM_LANES*3 | Failing-phase code, three bits per lane |
| mem_opt_o | output | NUM_LANES*NUM_RANKS*CODE_W | Chosen write code per lane/rank |
| host_opt_o | output | NUM_LANES*NUM_RANKS*CODE_W | Chosen read code per lane/rank |

## Verification
Every result of a handshake is due one cycle after the edge that ends the handshake cycle. This covers the next request fields, a committed optimum or error bit, a phase bit, and done. Busy and the cleared status are due one cycle after an accepted start. The bench drives the start and tester answers at falling edges. A behavioural model advances on the same rising edge as the design, and every output is compared at the next falling edge, when the registered values have settled. The tester waits 0 to 2 cycles before each answer, so the hold-until-valid rule is exercised between the compares.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

  typedef enum logic [2:0] {
    PH_INIT   = 3'd0,
    PH_MSWEEP = 3'd1,
    PH_MCHK   = 3'd2,
    PH_HSWEEP = 3'd3,
    PH_HCHK   = 3'd4
  } phase_e;

  // Midpoint of a passing run, lower middle for even lengths (R5)
  function automatic int run_mid(input int start, input int len);
    return start + (len - 1) / 2;
  endfunction

  // A candidate run replaces the best one only when strictly wider (R5 tie rule)
  function automatic bit run_beats(input int cand_len, input int best_len);
    return cand_len > best_len;
  endfunction

  function automatic bit is_sweep(input phase_e ph);
    return (ph == PH_MSWEEP) || (ph == PH_HSWEEP);
  endfunction

endpackage

// File: rtl/vrt_seq_ctrl.sv
module vrt_seq_ctrl
  import vrt_pkg::*;
#(
  parameter int NUM_LANES = 9,
  parameter int NUM_RANKS = 2,
  parameter int NUM_CODES = 16,
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rsp_valid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [LANE_W-1:0] lane_o,
  output logic [RANK_W-1:0] rank_o,
  output phase_e            phase_o,
  output logic [CODE_W-1:0] code_o,
  output logic              start_acc_o,
  output logic              hs_o,
  output logic              sweep_last_o
);

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);
  localparam logic [RANK_W-1:0] LAST_RANK = RANK_W'(NUM_RANKS - 1);
  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NUM_CODES - 1);

  logic              busy_q, done_q;
  logic [LANE_W-1:0] lane_q;
  logic [RANK_W-1:0] rank_q;
  phase_e            phase_q;
  logic [CODE_W-1:0] code_q;

  // R1: start only taken while idle
  assign start_acc_o  = start_i && !busy_q;
  // R3: the only advance event
  assign hs_o         = busy_q && rsp_valid_i;
  assign sweep_last_o = hs_o && is_sweep(phase_q) && (code_q == LAST_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      lane_q  <= '0;
      rank_q  <= '0;
      phase_q <= PH_INIT;
      code_q  <= '0;
    end else if (start_acc_o) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      lane_q  <= '0;
      rank_q  <= '0;
      phase_q <= PH_INIT;
      code_q  <= '0;
    end else if (hs_o) begin
      // R2: phase order per lane/rank
      unique case (phase_q)
        PH_INIT:   phase_q <= PH_MSWEEP;
        PH_MSWEEP: begin
          if (code_q == LAST_CODE) begin
            code_q  <= '0;
            phase_q <= PH_MCHK;
          end else begin
            code_q <= code_q + 1'b1;
          end
        end
        PH_MCHK:   phase_q <= PH_HSWEEP;
        PH_HSWEEP: begin
          if (code_q == LAST_CODE) begin
            code_q  <= '0;
            phase_q <= PH_HCHK;
          end else begin
            code_q <= code_q + 1'b1;
          end
        end
        PH_HCHK: begin
          phase_q <= PH_INIT;
          if (rank_q == LAST_RANK) begin
            rank_q <= '0;
            if (lane_q == LAST_LANE) begin
              // R9: sequence end
              lane_q <= '0;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              lane_q <= lane_q + 1'b1;
            end
          end else begin
            rank_q <= rank_q + 1'b1;
          end
        end
        default: phase_q <= PH_INIT;
      endcase
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign lane_o  = lane_q;
  assign rank_o  = rank_q;
  assign phase_o = phase_q;
  assign code_o  = code_q;

endmodule

// File: rtl/vrt_window_track.sv
module vrt_window_track
  import vrt_pkg::*;
#(
  parameter int NUM_CODES = 16,
  localparam int CODE_W = $clog2(NUM_CODES),
  localparam int LEN_W  = $clog2(NUM_CODES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              last_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              pass_i,
  output logic              found_o,
  output logic [CODE_W-1:0] opt_o
);

  logic [CODE_W-1:0] cur_start_q, best_start_q, cur_start_n, best_start_n;
  logic [LEN_W-1:0]  cur_len_q, best_len_q, cur_len_n, best_len_n;

  // Fold the current result into the running and best windows
  always_comb begin
    cur_start_n  = cur_start_q;
    cur_len_n    = '0;
    best_start_n = best_start_q;
    best_len_n   = best_len_q;
    if (pass_i) begin
      cur_len_n   = cur_len_q + 1'b1;
      cur_start_n = (cur_len_q == '0) ? code_i : cur_start_q;
      if (run_beats(int'(cur_len_n), int'(best_len_q))) begin
        best_start_n = cur_start_n;
        best_len_n   = cur_len_n;
      end
    end
  end

  // Valid in the last-code handshake cycle, including that code's result
  assign found_o = (best_len_n != '0);
  assign opt_o   = CODE_W'(run_mid(int'(best_start_n), int'(best_len_n)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (clear_i || last_i) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (step_i) begin
      cur_start_q  <= cur_start_n;
      cur_len_q    <= cur_len_n;
      best_start_q <= best_start_n;
      best_len_q   <= best_len_n;
    end
  end

endmodule

// File: rtl/vrt_status_bank.sv
module vrt_status_bank #(
  parameter int NUM_LANES = 9,
  parameter int NUM_RANKS = 2,
  parameter int NUM_CODES = 16,
  localparam int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int CODE_W    = $clog2(NUM_CODES),
  localparam int NUM_SLOTS = NUM_LANES * NUM_RANKS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_acc_i,
  input  logic [CODE_W-1:0]           init_mem_i,
  input  logic [CODE_W-1:0]           init_host_i,
  input  logic [LANE_W-1:0]           lane_i,
  input  logic [RANK_W-1:0]           rank_i,
  input  logic                        commit_mem_i,
  input  logic                        commit_host_i,
  input  logic                        found_i,
  input  logic [CODE_W-1:0]           opt_i,
  input  logic                        fail_init_i,
  input  logic                        fail_mchk_i,
  input  logic                        fail_hchk_i,
  output logic [NUM_SLOTS*CODE_W-1:0] mem_opt_o,
  output logic [NUM_SLOTS*CODE_W-1:0] host_opt_o,
  output logic [NUM_SLOTS-1:0]        mem_err_o,
  output logic [NUM_SLOTS-1:0]        host_err_o,
  output logic [NUM_LANES*3-1:0]      phase_err_o,
  output logic [CODE_W-1:0]           sel_mem_o,
  output logic [CODE_W-1:0]           sel_host_o,
  output logic                        any_err_o
);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic       lane_hit;
    logic [2:0] ph_q;

    assign lane_hit = (int'(lane_i) == l);

    // R7: per-lane failing-phase code
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph_q <= '0;
      end else if (start_acc_i) begin
        ph_q <= '0;
      end else if (lane_hit) begin
        if (fail_init_i) ph_q[0] <= 1'b1;
        if (fail_mchk_i) ph_q[1] <= 1'b1;
        if (fail_hchk_i) ph_q[2] <= 1'b1;
      end
    end
    assign phase_err_o[l*3 +: 3] = ph_q;

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      localparam int SLOT = l * NUM_RANKS + r;
      logic              hit;
      logic [CODE_W-1:0] mopt_q, hopt_q;
      logic              merr_q, herr_q;

      assign hit = lane_hit && (int'(rank_i) == r);

      // R5/R6: commit optimum or flag an empty sweep
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mopt_q <= '0;
          hopt_q <= '0;
          merr_q <= 1'b0;
          herr_q <= 1'b0;
        end else if (start_acc_i) begin
          mopt_q <= init_mem_i;
          hopt_q <= init_host_i;
          merr_q <= 1'b0;
          herr_q <= 1'b0;
        end else if (hit) begin
          if (commit_mem_i) begin
            if (found_i) mopt_q <= opt_i;
            else         merr_q <= 1'b1;
          end
          if (commit_host_i) begin
            if (found_i) hopt_q <= opt_i;
            else         herr_q <= 1'b1;
          end
        end
      end

      assign mem_opt_o[SLOT*CODE_W +: CODE_W]  = mopt_q;
      assign host_opt_o[SLOT*CODE_W +: CODE_W] = hopt_q;
      assign mem_err_o[SLOT]                   = merr_q;
      assign host_err_o[SLOT]                  = herr_q;
    end
  end

  int sel_idx;
  always_comb begin
    sel_idx    = int'(lane_i) * NUM_RANKS + int'(rank_i);
    sel_mem_o  = '0;
    sel_host_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (s == sel_idx) begin
        sel_mem_o  = mem_opt_o[s*CODE_W +: CODE_W];
        sel_host_o = host_opt_o[s*CODE_W +: CODE_W];
      end
    end
  end

  // R8
  assign any_err_o = (|mem_err_o) || (|host_err_o) || (|phase_err_o);

endmodule

// File: rtl/vrt_train_seq.sv
module vrt_train_seq
  import vrt_pkg::*;
#(
  parameter int NUM_LANES = 9,
  parameter int NUM_RANKS = 2,
  parameter int NUM_CODES = 16,
  localparam int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int CODE_W    = $clog2(NUM_CODES),
  localparam int NUM_SLOTS = NUM_LANES * NUM_RANKS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [CODE_W-1:0]           init_mem_code_i,
  input  logic [CODE_W-1:0]           init_host_code_i,
  output logic                        req_o,
  output logic [LANE_W-1:0]           req_lane_o,
  output logic [RANK_W-1:0]           req_rank_o,
  output logic [2:0]                  req_phase_o,
  output logic [CODE_W-1:0]           req_mem_code_o,
  output logic [CODE_W-1:0]           req_host_code_o,
  input  logic                        rsp_valid_i,
  input  logic                        rsp_pass_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        err_o,
  output logic [NUM_SLOTS-1:0]        mem_err_o,
  output logic [NUM_SLOTS-1:0]        host_err_o,
  output logic [NUM_LANES*3-1:0]      phase_err_o,
  output logic [NUM_SLOTS*CODE_W-1:0] mem_opt_o,
  output logic [NUM_SLOTS*CODE_W-1:0] host_opt_o
);

  // Named internal events
  logic              start_acc, hs, sweep_last, sweep_step;
  logic              commit_mem, commit_host;
  logic              fail_init, fail_mchk, fail_hchk;
  logic              found;
  logic [CODE_W-1:0] win_opt, sweep_code, sel_mem, sel_host;
  logic [LANE_W-1:0] lane;
  logic [RANK_W-1:0] rank;
  phase_e            phase;

  vrt_seq_ctrl #(
    .NUM_LANES(NUM_LANES), .NUM_RANKS(NUM_RANKS), .NUM_CODES(NUM_CODES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .rsp_valid_i  (rsp_valid_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .lane_o       (lane),
    .rank_o       (rank),
    .phase_o      (phase),
    .code_o       (sweep_code),
    .start_acc_o  (start_acc),
    .hs_o         (hs),
    .sweep_last_o (sweep_last)
  );

  assign sweep_step  = hs && is_sweep(phase);
  assign commit_mem  = sweep_last && (phase == PH_MSWEEP);
  assign commit_host = sweep_last && (phase == PH_HSWEEP);
  assign fail_init   = hs && (phase == PH_INIT) && !rsp_pass_i;
  assign fail_mchk   = hs && (phase == PH_MCHK) && !rsp_pass_i;
  assign fail_hchk   = hs && (phase == PH_HCHK) && !rsp_pass_i;

  vrt_window_track #(.NUM_CODES(NUM_CODES)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_acc),
    .step_i  (sweep_step),
    .last_i  (sweep_last),
    .code_i  (sweep_code),
    .pass_i  (rsp_pass_i),
    .found_o (found),
    .opt_o   (win_opt)
  );

  vrt_status_bank #(
    .NUM_LANES(NUM_LANES), .NUM_RANKS(NUM_RANKS), .NUM_CODES(NUM_CODES)
  ) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_acc_i   (start_acc),
    .init_mem_i    (init_mem_code_i),
    .init_host_i   (init_host_code_i),
    .lane_i        (lane),
    .rank_i        (rank),
    .commit_mem_i  (commit_mem),
    .commit_host_i (commit_host),
    .found_i       (found),
    .opt_i         (win_opt),
    .fail_init_i   (fail_init),
    .fail_mchk_i   (fail_mchk),
    .fail_hchk_i   (fail_hchk),
    .mem_opt_o     (mem_opt_o),
    .host_opt_o    (host_opt_o),
    .mem_err_o     (mem_err_o),
    .host_err_o    (host_err_o),
    .phase_err_o   (phase_err_o),
    .sel_mem_o     (sel_mem),
    .sel_host_o    (sel_host),
    .any_err_o     (err_o)
  );

  // R4: stored optima stand in for the starting codes until committed
  assign req_o           = busy_o;
  assign req_lane_o      = lane;
  assign req_rank_o      = rank;
  assign req_phase_o     = phase;
  assign req_mem_code_o  = (phase == PH_MSWEEP) ? sweep_code : sel_mem;
  assign req_host_code_o = (phase == PH_HSWEEP) ? sweep_code : sel_host;

endmodule

// File: rtl/vrt_train_chk.sv
module vrt_train_chk #(
  parameter int CODE_W    = 4,
  parameter int NUM_CODES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              req_o,
  input logic              rsp_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [2:0]        req_phase_o,
  input logic [CODE_W-1:0] req_mem_code_o,
  input logic [CODE_W-1:0] req_host_code_o,
  input logic              start_acc,
  input logic              hs,
  input logic              commit_mem,
  input logic              commit_host
);

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy_o && !done_o && !err_o);

  a_r1_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !rsp_valid_i |=> busy_o && $stable(req_phase_o));

  a_r3_hold_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !rsp_valid_i |=> $stable(req_phase_o) && $stable(req_mem_code_o)
                               && $stable(req_host_code_o));

  a_r2_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> req_phase_o <= 3'd4);

  a_r2_write_commit_next: assert property (@(posedge clk) disable iff (!rst_n)
    commit_mem |=> req_phase_o == 3'd2);

  a_r2_read_commit_next: assert property (@(posedge clk) disable iff (!rst_n)
    commit_host |=> req_phase_o == 3'd4);

  a_r4_last_sweep_code: assert property (@(posedge clk) disable iff (!rst_n)
    commit_mem |-> req_mem_code_o == CODE_W'(NUM_CODES - 1));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !req_o);

  a_r9_done_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(hs));

endmodule

bind vrt_train_seq vrt_train_chk #(.CODE_W(CODE_W), .NUM_CODES(NUM_CODES)) u_chk (.*);

// File: tb/vrt_train_seq_tb.sv
`timescale 1ns/1ps
module vrt_train_seq_tb;

  localparam int NL = 9, NR = 2, NC = 16, CW = 4, LW = 4, RW = 1;
  localparam int NS = NL * NR;
  localparam int INIT_M = 7, INIT_H = 6;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic rsp_valid_i = 1'b0, rsp_pass_i = 1'b0;
  logic [CW-1:0] init_mem_code_i = CW'(INIT_M), init_host_code_i = CW'(INIT_H);
  logic req_o, busy_o, done_o, err_o;
  logic [LW-1:0] req_lane_o;
  logic [RW-1:0] req_rank_o;
  logic [2:0] req_phase_o;
  logic [CW-1:0] req_mem_code_o, req_host_code_o;
  logic [NS-1:0] mem_err_o, host_err_o;
  logic [NL*3-1:0] phase_err_o;
  logic [NS*CW-1:0] mem_opt_o, host_opt_o;

  vrt_train_seq u_dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, cycles = 0, scen = 0, wait_cnt = 0, hs_seen = 0;

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Tester behaviour
  function automatic bit in_rng(input int v, input int lo, input int hi);
    return v >= lo && v <= hi;
  endfunction

  function automatic bit tpass(input int l, input int r, input int ph, input int mc, input int hc);
    int lo_m, hi_m, lo_h, hi_h;
    lo_m = (l + r) % 4 + 2;  hi_m = lo_m + 4 + l % 3;
    lo_h = (l * 3 + r) % 5;  hi_h = lo_h + 5;
    case (ph)
      0: return !(scen == 2 && l == 0);
      1: begin
        if (scen == 1 && l == 3 && r == 1) return 0;
        if (scen == 3 && l == 0) return in_rng(mc, 2, 4) || in_rng(mc, 8, 10);
        if (scen == 3 && l == 1) return in_rng(mc, 12, 15);
        return in_rng(mc, lo_m, hi_m);
      end
      2: return !(scen == 2 && l == 8) && in_rng(mc, lo_m, hi_m);
      3: return !(scen == 1 && l == 6 && r == 0) && in_rng(hc, lo_h, hi_h);
      default: return !(scen == 2 && l == 5) && in_rng(hc, lo_h, hi_h);
    endcase
  endfunction

  always @(negedge clk) begin
    rsp_valid_i = 1'b0;
    if (rst_n && req_o) begin
      if (wait_cnt == 0) begin
        rsp_valid_i = 1'b1;
        rsp_pass_i  = tpass(int'(req_lane_o), int'(req_rank_o), int'(req_phase_o),
                            int'(req_mem_code_o), int'(req_host_code_o));
        hs_seen++;
        wait_cnt = hs_seen % 3;
      end else begin
        wait_cnt--;
      end
    end
  end

  // Behavioural reference model
  int m_busy, m_done, m_lane, m_rank, m_ph, m_code;
  int m_mopt[NL][NR], m_hopt[NL][NR], m_merr[NL][NR], m_herr[NL][NR], m_pe[NL][3];
  int m_pmap[NC];

  function automatic int best_mid();
    int bl = 0, bs = 0;
    for (int s = 0; s < NC; s++) begin
      for (int len = 1; s + len <= NC; len++) begin
        bit ok;
        ok = 1;
        for (int k = s; k < s + len; k++) if (m_pmap[k] == 0) ok = 0;
        if (ok && len > bl) begin bl = len; bs = s; end
      end
    end
    if (bl == 0) return -1;
    return bs + (bl - 1) / 2;
  endfunction

  task automatic m_clear(input int mv, input int hv);
    for (int l = 0; l < NL; l++) begin
      for (int r = 0; r < NR; r++) begin
        m_mopt[l][r] = mv; m_hopt[l][r] = hv; m_merr[l][r] = 0; m_herr[l][r] = 0;
      end
      for (int k = 0; k < 3; k++) m_pe[l][k] = 0;
    end
    m_lane = 0; m_rank = 0; m_ph = 0; m_code = 0;
  endtask

  task automatic m_step(input int p);
    int b;
    case (m_ph)
      0: begin if (p == 0) m_pe[m_lane][0] = 1; m_ph = 1; m_code = 0; end
      1, 3: begin
        m_pmap[m_code] = p;
        if (m_code == NC - 1) begin
          b = best_mid();
          if (m_ph == 1) begin
            if (b < 0) m_merr[m_lane][m_rank] = 1; else m_mopt[m_lane][m_rank] = b;
          end else begin
            if (b < 0) m_herr[m_lane][m_rank] = 1; else m_hopt[m_lane][m_rank] = b;
          end
          m_ph = m_ph + 1; m_code = 0;
        end else m_code++;
      end
      2: begin if (p == 0) m_pe[m_lane][1] = 1; m_ph = 3; end
      default: begin
        if (p == 0) m_pe[m_lane][2] = 1;
        m_ph = 0;
        if (m_rank == NR - 1) begin
          m_rank = 0;
          if (m_lane == NL - 1) begin m_lane = 0; m_busy = 0; m_done = 1; end
          else m_lane++;
        end else m_rank++;
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_clear(0, 0);
    end else if (m_busy == 1 && rsp_valid_i) begin
      m_step(int'(rsp_pass_i));
    end else if (m_busy == 0 && start_i) begin
      m_busy = 1; m_done = 0;
      m_clear(int'(init_mem_code_i), int'(init_host_code_i));
    end
  end

  function automatic logic [127:0] v_opt(input bit host);
    logic [127:0] v = '0;
    for (int l = 0; l < NL; l++)
      for (int r = 0; r < NR; r++)
        v[(l*NR+r)*CW +: CW] = CW'(host ? m_hopt[l][r] : m_mopt[l][r]);
    return v;
  endfunction

  function automatic logic [127:0] v_err(input bit host);
    logic [127:0] v = '0;
    for (int l = 0; l < NL; l++)
      for (int r = 0; r < NR; r++)
        v[l*NR+r] = (host ? m_herr[l][r] : m_merr[l][r]) != 0;
    return v;
  endfunction

  function automatic logic [127:0] v_pe();
    logic [127:0] v = '0;
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < 3; k++) v[l*3+k] = m_pe[l][k] != 0;
    return v;
  endfunction

  // Every-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 busy_o", busy_o, m_busy != 0);
      chk("R9 done_o", done_o, m_done != 0);
      chk("R9 req_o", req_o, m_busy != 0);
      chk("R8 err_o", err_o, (v_err(0) | v_err(1) | v_pe()) != 0);
      chk("R6 mem_err_o", mem_err_o, v_err(0));
      chk("R6 host_err_o", host_err_o, v_err(1));
      chk("R7 phase_err_o", phase_err_o, v_pe());
      chk("R5 mem_opt_o", mem_opt_o, v_opt(0));
      chk("R5 host_opt_o", host_opt_o, v_opt(1));
      if (m_busy != 0) begin
        chk("R2 req_lane_o", req_lane_o, m_lane);
        chk("R2 req_rank_o", req_rank_o, m_rank);
        chk("R2 req_phase_o", req_phase_o, m_ph);
        chk("R3 R4 req_mem_code_o", req_mem_code_o, m_ph == 1 ? m_code : m_mopt[m_lane][m_rank]);
        chk("R3 R4 req_host_code_o", req_host_code_o, m_ph == 3 ? m_code : m_hopt[m_lane][m_rank]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic kick(input int s);
    @(negedge clk);
    scen = s;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R1 busy after start", busy_o, 1);
    chk("R1 done cleared", done_o, 0);
    chk("R1 err cleared", err_o, 0);
    chk("R1 mem_err cleared", mem_err_o, 0);
    chk("R1 opt loaded", mem_opt_o[CW-1:0], INIT_M);
  endtask

  task automatic finish_run();
    while (done_o !== 1'b1) @(negedge clk);
    chk("R9 req low at done", req_o, 0);
    chk("R9 busy low at done", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset busy", busy_o, 0);
    chk("R10 reset done", done_o, 0);
    chk("R10 reset err", err_o, 0);
    chk("R10 reset req", req_o, 0);
    chk("R10 reset opt", mem_opt_o | host_opt_o, 0);
    chk("R10 reset phase", phase_err_o, 0);
    rst_n = 1'b1;

    kick(0);
    finish_run();
    chk("R8 no errors", err_o, 0);
    chk("R5 mem opt lane0 rank0", mem_opt_o[0 +: CW], 4);
    chk("R5 host opt lane0 rank0", host_opt_o[0 +: CW], 2);

    kick(1);
    finish_run();
    chk("R6 mem_err lane3 rank1", mem_err_o[7], 1);
    chk("R6 mem opt kept", mem_opt_o[7*CW +: CW], INIT_M);
    chk("R6 host_err lane6 rank0", host_err_o[12], 1);
    chk("R6 host opt kept", host_opt_o[12*CW +: CW], INIT_H);
    chk("R7 write check lane3", phase_err_o[10], 1);
    chk("R8 err set", err_o, 1);

    kick(2);
    finish_run();
    chk("R7 init fail lane0", phase_err_o[0], 1);
    chk("R7 write check lane8", phase_err_o[25], 1);
    chk("R7 read check lane5", phase_err_o[17], 1);
    chk("R7 phase bit count", $countones(phase_err_o), 3);
    chk("R8 err from phase", err_o, 1);

    kick(3);
    while (req_lane_o != LW'(2)) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R1 busy start ignored lane", req_lane_o, 2);
    chk("R1 busy start ignored busy", busy_o, 1);
    finish_run();
    chk("R5 tie lower run r0", mem_opt_o[0 +: CW], 3);
    chk("R5 tie lower run r1", mem_opt_o[CW +: CW], 3);
    chk("R5 run at top edge", mem_opt_o[2*CW +: CW], 13);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule